// File: doc/BRIEF.md
# Three-Voice Waveform Oscillator Bank

This block holds three tone voices. Each voice is a 24-bit phase accumulator that advances by its own 16-bit frequency word on every sample enable. From the accumulator it builds a 12-bit triangle, sawtooth, pulse or noise sample. A host programs the voices through a byte-wide register port that can only be written. Each voice has a control byte that picks the waveforms, holds the voice in its test state, and turns on sync or ring modulation.

The three voices are linked in a fixed ring. Voice 0 takes voice 2 as its modulation source, voice 1 takes voice 0, and voice 2 takes voice 1. With sync on, a voice restarts its phase when the MSB of its source rises. With ring modulation on, the triangle fold of a voice is flipped by the MSB of its source. The samples are combinational from the block's registers and go to envelope and mixing logic outside the block.

Top module: `osc_bank`

## Requirements
- R1: After reset every register is zero, every accumulator is zero and every noise register holds 23'h7FFFF8. All three outputs are therefore 0. Selecting noise alone at this point gives 12'hFE0.
- R2: Voice v (0..2) has its base address at 7*v. The frequency low byte is at base+0 and the high byte at base+1. A write takes effect on the clock edge where `wr_en_i` is high. The accumulator adds the zero-extended frequency at each clock with `smp_en_i` high and holds its value when `smp_en_i` is low.
- R3: Control bit 5 selects sawtooth. The sawtooth sample is accumulator bits 23:12.
- R4: Control bit 4 selects triangle. The triangle sample is {bits 22:12, 1'b0}. When the fold bit is 1, bits 22:12 are inverted before use. Without ring modulation, the fold bit is accumulator bit 23.
- R5: Control bit 6 selects pulse. The pulse width is 12 bits: the low byte is at base+2 and the high nibble is bits 3:0 of base+3. Bits 7:4 of base+3 are ignored. The pulse sample is 12'hFFF while accumulator bits 23:12 are greater than or equal to the width, and 0 otherwise.
- R6: Control bit 7 selects noise. The noise register shifts left and takes bit 22 XOR bit 17 into bit 0. It shifts on each enable where accumulator bit 19 goes from 0 to 1. The noise sample is register bits {22,20,16,13,11,7,4,2} followed by four zero bits.
- R7: While control bit 3 (test) is set, the accumulator is forced to 0 and the noise register to its seed on every clock, whatever the value of `smp_en_i`.
- R8: Control bit 1 (sync) makes a voice load 0 instead of adding at the first enable that follows an enable in which the MSB of its source accumulator rose.
- R9: Control bit 2 (ring) makes the triangle fold bit equal to the voice's own bit 23 XOR the bit 23 of its source. Sources: voice 0 uses voice 2, voice 1 uses voice 0, voice 2 uses voice 1.
- R10: When several waveform bits are set, the output is the bitwise AND of the selected samples. When no waveform bit is set, the output is 0.
- R11: Writes have no effect at base+5, at base+6, at addresses 21 to 31, and on control bit 0 (gate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 8 | Register write data |
| smp_en_i | input | 1 | Sample enable, advances all voices |
| wave0_o | output | 12 | Voice 0 sample |
| wave1_o | output | 12 | Voice 1 sample |
| wave2_o | output | 12 | Voice 2 sample |

## Verification
A register write is visible at the outputs at the next falling edge, because the samples are combinational from the configuration registers. A test bit clears the accumulator one edge later, so the bench waits one extra cycle before it checks the cleared state. After n enables the bench expects exactly n additions of the frequency word, or a zero load at enable 257 in the sync case. The driver pushes each expected sample only after the last edge that could change it, and the monitor compares at the falling edge that follows.

// File: rtl/osc_bank_pkg.sv
package osc_bank_pkg;
  localparam int NV        = 3;
  localparam int ACC_W     = 24;
  localparam int FREQ_W    = 16;
  localparam int PW_W      = 12;
  localparam int OUT_W     = 12;
  localparam int LFSR_W    = 23;
  localparam int NOISE_BIT = 19;
  localparam int STRIDE    = 7;
  localparam int ADDR_W    = 5;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h7FFFF8;

  typedef struct packed {
    logic noise;
    logic pulse;
    logic saw;
    logic tri_w;
    logic test;
    logic ring;
    logic sync;
  } ctrl_t;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [PW_W-1:0]   pw;
    ctrl_t             ctrl;
  } voice_cfg_t;
endpackage

// File: rtl/osc_regs.sv
module osc_regs
  import osc_bank_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [7:0]               wr_data_i,
  output voice_cfg_t [NV-1:0]      cfg_o
);
  localparam int PW_HI_W = PW_W - 8;

  for (genvar v = 0; v < NV; v++) begin : g_voice
    localparam int BASE = v * STRIDE;
    voice_cfg_t cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(BASE + 0)) cfg_q.freq[7:0]      <= wr_data_i;
        if (wr_addr_i == ADDR_W'(BASE + 1)) cfg_q.freq[15:8]     <= wr_data_i;
        if (wr_addr_i == ADDR_W'(BASE + 2)) cfg_q.pw[7:0]        <= wr_data_i;
        if (wr_addr_i == ADDR_W'(BASE + 3)) cfg_q.pw[PW_W-1:8]   <= wr_data_i[PW_HI_W-1:0];
        // bit 0 (gate) belongs to the envelope, not stored here
        if (wr_addr_i == ADDR_W'(BASE + 4)) cfg_q.ctrl           <= wr_data_i[7:1];
      end
    end

    assign cfg_o[v] = cfg_q;
  end
endmodule

// File: rtl/osc_voice.sv
module osc_voice
  import osc_bank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_en_i,
  input  voice_cfg_t         cfg_i,
  input  logic               src_msb_i,
  input  logic               src_rise_i,
  output logic               msb_o,
  output logic               rise_o,
  output logic [ACC_W-1:0]   acc_o,
  output logic [OUT_W-1:0]   wave_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0]  acc_q, acc_nxt;
  logic [LFSR_W-1:0] lfsr_q;
  logic              msb_q;
  logic              sync_clr, noise_clk, fold;
  logic [OUT_W-1:0]  saw_s, tri_s, pul_s, noi_s, mix;
  logic [OUT_W-2:0]  tri_half;

  assign sync_clr  = cfg_i.ctrl.sync & src_rise_i;
  assign acc_nxt   = sync_clr ? '0 : acc_q + ACC_W'(cfg_i.freq);
  assign noise_clk = acc_nxt[NOISE_BIT] & ~acc_q[NOISE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else if (cfg_i.ctrl.test) begin
      acc_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else if (smp_en_i) begin
      acc_q <= acc_nxt;
      if (noise_clk) lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[22] ^ lfsr_q[17]};
    end
  end

  // MSB seen at the previous enable, for the neighbour's sync edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       msb_q <= 1'b0;
    else if (smp_en_i) msb_q <= acc_q[MSB];
  end

  assign msb_o  = acc_q[MSB];
  assign rise_o = acc_q[MSB] & ~msb_q;
  assign acc_o  = acc_q;

  assign fold     = acc_q[MSB] ^ (cfg_i.ctrl.ring & src_msb_i);
  assign tri_half = acc_q[MSB-1 -: OUT_W-1];
  assign tri_s    = {fold ? ~tri_half : tri_half, 1'b0};
  assign saw_s    = acc_q[MSB -: OUT_W];
  assign pul_s    = (saw_s >= cfg_i.pw) ? '1 : '0;
  assign noi_s    = {lfsr_q[22], lfsr_q[20], lfsr_q[16], lfsr_q[13],
                     lfsr_q[11], lfsr_q[7],  lfsr_q[4],  lfsr_q[2], 4'b0000};

  always_comb begin
    mix = '1;
    if (cfg_i.ctrl.tri_w) mix &= tri_s;
    if (cfg_i.ctrl.saw)   mix &= saw_s;
    if (cfg_i.ctrl.pulse) mix &= pul_s;
    if (cfg_i.ctrl.noise) mix &= noi_s;
    if (!(cfg_i.ctrl.tri_w | cfg_i.ctrl.saw | cfg_i.ctrl.pulse | cfg_i.ctrl.noise))
      mix = '0;
  end

  assign wave_o = mix;
endmodule

// File: rtl/osc_bank.sv
module osc_bank
  import osc_bank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               smp_en_i,
  output logic [OUT_W-1:0]   wave0_o,
  output logic [OUT_W-1:0]   wave1_o,
  output logic [OUT_W-1:0]   wave2_o
);
  voice_cfg_t [NV-1:0]            cfg;
  logic       [NV-1:0][ACC_W-1:0] acc;
  logic       [NV-1:0][OUT_W-1:0] wave;
  logic       [NV-1:0]            msb, rise;

  osc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  for (genvar v = 0; v < NV; v++) begin : g_voice
    localparam int SRC = (v + NV - 1) % NV;
    osc_voice u_voice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_en_i   (smp_en_i),
      .cfg_i      (cfg[v]),
      .src_msb_i  (msb[SRC]),
      .src_rise_i (rise[SRC]),
      .msb_o      (msb[v]),
      .rise_o     (rise[v]),
      .acc_o      (acc[v]),
      .wave_o     (wave[v])
    );
  end

  assign wave0_o = wave[0];
  assign wave1_o = wave[1];
  assign wave2_o = wave[2];
endmodule

// File: rtl/osc_bank_chk.sv
module osc_bank_chk
  import osc_bank_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         smp_en_i,
  input voice_cfg_t [NV-1:0]          cfg_i,
  input logic [NV-1:0][ACC_W-1:0]     acc_i,
  input logic [NV-1:0]                rise_i,
  input logic [NV-1:0][OUT_W-1:0]     wave_i
);
  for (genvar v = 0; v < NV; v++) begin : g_chk
    localparam int SRC = (v + NV - 1) % NV;

    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_en_i && !cfg_i[v].ctrl.test) |=> $stable(acc_i[v]));

    a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_en_i && !cfg_i[v].ctrl.test && !(cfg_i[v].ctrl.sync && rise_i[SRC]))
      |=> acc_i[v] == $past(acc_i[v]) + ACC_W'($past(cfg_i[v].freq)));

    a_r7_test_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i[v].ctrl.test |=> acc_i[v] == '0);

    a_r8_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_en_i && !cfg_i[v].ctrl.test && cfg_i[v].ctrl.sync && rise_i[SRC])
      |=> acc_i[v] == '0);

    a_r3_saw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({cfg_i[v].ctrl.noise, cfg_i[v].ctrl.pulse, cfg_i[v].ctrl.saw, cfg_i[v].ctrl.tri_w} == 4'b0010)
      |-> wave_i[v] == acc_i[v][ACC_W-1 -: OUT_W]);

    a_r5_pulse_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({cfg_i[v].ctrl.noise, cfg_i[v].ctrl.pulse, cfg_i[v].ctrl.saw, cfg_i[v].ctrl.tri_w} == 4'b0100)
      |-> (wave_i[v] == '0 || wave_i[v] == '1));

    a_r10_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({cfg_i[v].ctrl.noise, cfg_i[v].ctrl.pulse, cfg_i[v].ctrl.saw, cfg_i[v].ctrl.tri_w} == 4'b0000)
      |-> wave_i[v] == '0);
  end
endmodule

bind osc_bank osc_bank_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_en_i (smp_en_i),
  .cfg_i    (cfg),
  .acc_i    (acc),
  .rise_i   (rise),
  .wave_i   (wave)
);

// File: tb/osc_bank_tb.sv
module osc_bank_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          voice;
    logic [11:0] exp;
    string       req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       smp_en = 1'b0;
  logic [11:0] w0, w1, w2;

  int n_chk = 0;
  int n_fail = 0;
  item_t sb_q[$];
  event  sample_ev;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .smp_en_i(smp_en),
    .wave0_o(w0), .wave1_o(w1), .wave2_o(w2)
  );

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    @(negedge clk);
    smp_en = 1'b1;
    repeat (n) @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(input int v, input logic [11:0] e, input string r);
    item_t it;
    it.voice = v; it.exp = e; it.req = r;
    sb_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [11:0] act;
        it = sb_q.pop_front();
        act = (it.voice == 0) ? w0 : (it.voice == 1) ? w1 : w2;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s voice%0d act=%03h exp=%03h", it.req, it.voice, act, it.exp);
        end
      end
    end
  end

  function automatic logic [22:0] lfsr_next(input logic [22:0] l);
    return {l[21:0], l[22] ^ l[17]};
  endfunction

  function automatic logic [11:0] noise_of(input logic [22:0] l);
    return {l[22], l[20], l[16], l[13], l[11], l[7], l[4], l[2], 4'b0000};
  endfunction

  initial begin
    logic [22:0] lm;
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    expect_v(0, 12'h000, "R1");
    expect_v(1, 12'h000, "R1");
    expect_v(2, 12'h000, "R1");
    wr(5'd18, 8'h80);
    expect_v(2, 12'hFE0, "R1");

    // R2/R3 frequency and sawtooth: 0x8000 x 3 = 0x018000
    wr(5'd1, 8'h80);
    wr(5'd4, 8'h20);
    step(3);
    expect_v(0, 12'h018, "R3");
    tick(5);
    expect_v(0, 12'h018, "R2");

    // R11 unmapped addresses and gate
    wr(5'd5, 8'hFF);
    wr(5'd6, 8'hFF);
    wr(5'd21, 8'hFF);
    wr(5'd24, 8'hFF);
    wr(5'd31, 8'hFF);
    expect_v(0, 12'h018, "R11");
    expect_v(2, 12'hFE0, "R11");
    step(1);
    expect_v(0, 12'h020, "R11");

    // 300 steps: acc = 0x960000
    step(296);
    expect_v(0, 12'h960, "R3");
    wr(5'd4, 8'h10);
    expect_v(0, 12'hD3E, "R4");
    wr(5'd4, 8'h30);
    expect_v(0, 12'h920, "R10");

    // R5 pulse boundary, high nibble bits 7:4 ignored
    wr(5'd2, 8'h60);
    wr(5'd3, 8'hF9);
    wr(5'd4, 8'h40);
    expect_v(0, 12'hFFF, "R5");
    wr(5'd2, 8'h61);
    expect_v(0, 12'h000, "R5");
    wr(5'd4, 8'h60);
    expect_v(0, 12'h000, "R10");

    // R7 test bit
    wr(5'd4, 8'h28);
    tick(1);
    expect_v(0, 12'h000, "R7");
    step(10);
    expect_v(0, 12'h000, "R7");
    wr(5'd4, 8'h20);
    step(1);
    expect_v(0, 12'h008, "R3");

    // R6 noise: 100 steps of 0x8000, bit 19 rises at 16, 48, 80
    wr(5'd15, 8'h80);
    step(100);
    lm = 23'h7FFFF8;
    repeat (3) lm = lfsr_next(lm);
    expect_v(2, noise_of(lm), "R6");
    wr(5'd18, 8'h88);
    tick(1);
    expect_v(2, 12'hFE0, "R7");

    // R9 ring: v0 freq 0x0100, v2 freq 0x8000, 256 steps
    wr(5'd0, 8'h00);
    wr(5'd1, 8'h01);
    wr(5'd4, 8'h08);
    tick(1);
    wr(5'd4, 8'h10);
    wr(5'd18, 8'h00);
    step(256);
    expect_v(0, 12'h020, "R4");
    wr(5'd4, 8'h14);
    expect_v(0, 12'hFDE, "R9");

    // R8 sync: v1 follows v0 (freq 0x8000); v1 freq 0x1000
    wr(5'd1, 8'h80);
    wr(5'd8, 8'h10);
    wr(5'd4, 8'h08);
    wr(5'd11, 8'h08);
    tick(1);
    wr(5'd4, 8'h20);
    wr(5'd11, 8'h22);
    step(256);
    expect_v(1, 12'h100, "R8");
    step(1);
    expect_v(1, 12'h000, "R8");
    step(1);
    expect_v(1, 12'h001, "R8");
    wr(5'd11, 8'h23);
    expect_v(1, 12'h001, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule